// File: doc/BRIEF.md
# High-Resolution PWM Edge Controller

This block produces an up-counting pulse-width waveform from a time-base counter, a period value and a coarse compare value. Alongside the waveform it emits an 8-bit fine edge-position code, meant for an external delay element that shifts the coarse edge by a fraction of a clock. It also emits a one-hot tag that says whether the code belongs to a rising or a falling edge. A configuration word picks which edges get fine control and whether the code follows the duty path or the phase path. It also picks the counter event at which shadowed fine and coarse compare values become active.

Software reaches the block through a single write port. It has five registers: configuration, period, coarse compare shadow, fine compare shadow and fine phase. The waveform comes from a two-state machine. WV_LOW moves to WV_HIGH on the RISE transition, taken when the counter is zero and does not match the compare. WV_HIGH moves to WV_LOW on the FALL transition, taken when the counter matches the active coarse compare. In every other cycle the machine holds its state. Each RISE or FALL produces one registered tag pulse and a code in the same cycle as the output change.

Top module: `fine_edge_pwm`

## Requirements
- R1: The counter advances by one each clock and returns to zero on the clock after it equals the period. `pwm_out` goes high the clock after the counter is zero, unless the counter also matches the active coarse compare. It goes low the clock after the counter matches the active coarse compare.
- R2: With fine control off, the coarse load mode (config bits [5:4]) sets when the coarse shadow is copied to active: 00 at counter zero, 01 at counter equal period, 10 at either event, 11 never.
- R3: `edge_tag` is one-hot or zero: bit 0 marks a rising edge and bit 1 a falling edge. It pulses for exactly the cycle in which `pwm_out` changes, and is zero otherwise.
- R4: The edge mode (config bits [1:0]) gates the code: 00 none, 01 rising only, 10 falling only, 11 both. `fine_code` is zero for an unselected edge and in every cycle without a tag.
- R5: Config bit 2 selects the code source: 0 takes the active fine compare value (duty control), 1 takes the fine phase register, which acts from the next clock.
- R6: In duty control, config bit 3 selects when the fine compare shadow is copied to active: 0 at counter zero, 1 at counter equal period.
- R7: In phase control, config bit 3 has no effect: the fine compare shadow is copied to active at counter zero.
- R8: The fine compare and fine phase values sit in data bits [15:8] of their writes. Bits [7:0] are ignored.
- R9: If the coarse load mode is 10 or 11 while the edge mode is non-zero, `cfg_err` is set on the next clock and stays set until reset. While the mode persists, coarse loads follow the event chosen by config bit 3.
- R10: Under reset, `pwm_out`, `fine_code`, `edge_tag` and `cfg_err` are zero, and every register is cleared.
- R11: Write addresses are 0 config, 1 period, 2 coarse compare shadow, 3 fine compare shadow, 4 fine phase. A write takes effect on the next clock, and writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PWM clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_out | output | 1 | Coarse PWM waveform |
| fine_code | output | 8 | Fine edge-position code |
| edge_tag | output | 2 | One-hot edge tag, bit 0 rising, bit 1 falling |
| cfg_err | output | 1 | Sticky illegal load-mode flag |

## Verification
A wrong machine state shows up as `pwm_out` at the wrong level, without a matching tag pulse, on the very next clock. A misplaced shadow-to-active copy shows up when the following RISE or FALL is emitted, either at the wrong counter value or carrying a stale code. That is at most one period after the faulty load. A bad load-mode decision in the error case shows the same way, and a lost sticky bit shows on `cfg_err` within one clock. The bench runs a cycle-level reference alongside the design and compares all four outputs every cycle. A divergence is therefore reported at the first port where it becomes visible.

// File: rtl/fine_edge_pkg.sv
package fine_edge_pkg;

    // coarse compare shadow load policy
    typedef enum logic [1:0] {
        LD_ZERO   = 2'b00,
        LD_PRD    = 2'b01,
        LD_BOTH   = 2'b10,
        LD_FREEZE = 2'b11
    } cload_e;

    // configuration word, bit 0 at the bottom
    typedef struct packed {
        cload_e     cload;      // [5:4]
        logic       load_sel;   // [3]
        logic       ctl_phase;  // [2]
        logic [1:0] edge_mode;  // [1:0]
    } cfg_t;

    localparam int CFG_W = $bits(cfg_t);

    typedef enum logic {
        WV_LOW  = 1'b0,
        WV_HIGH = 1'b1
    } wave_e;

    localparam int A_CFG   = 0;
    localparam int A_PRD   = 1;
    localparam int A_CMP   = 2;
    localparam int A_FINE  = 3;
    localparam int A_PHASE = 4;

endpackage

// File: rtl/fe_regs.sv
module fe_regs
    import fine_edge_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int FINE_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ev_zero,
    input  logic              ev_prd,
    output logic [1:0]        edge_mode,
    output logic              ctl_phase,
    output logic [CNT_W-1:0]  period_q,
    output logic [CNT_W-1:0]  cmp_act_q,
    output logic [FINE_W-1:0] fine_act_q,
    output logic [FINE_W-1:0] phase_q,
    output logic              err_q
);

    localparam int FINE_LSB = DATA_W - FINE_W;

    cfg_t              cfg_q;
    logic [CNT_W-1:0]  cmp_sh_q;
    logic [FINE_W-1:0] fine_sh_q;

    logic fine_en, sel_ev, cmp_ld, fine_ld, bad_mode;
    logic we_cfg, we_prd, we_cmp, we_fine, we_phase;

    assign we_cfg   = wr_en && (wr_addr == ADDR_W'(A_CFG));
    assign we_prd   = wr_en && (wr_addr == ADDR_W'(A_PRD));
    assign we_cmp   = wr_en && (wr_addr == ADDR_W'(A_CMP));
    assign we_fine  = wr_en && (wr_addr == ADDR_W'(A_FINE));
    assign we_phase = wr_en && (wr_addr == ADDR_W'(A_PHASE));

    assign fine_en  = (cfg_q.edge_mode != 2'b00);
    assign sel_ev   = cfg_q.load_sel ? ev_prd : ev_zero;
    assign bad_mode = fine_en && cfg_q.cload[1];

    // coarse load event: illegal modes fall back to the load-select event
    always_comb begin
        cmp_ld = 1'b0;
        unique case (cfg_q.cload)
            LD_ZERO:   cmp_ld = ev_zero;
            LD_PRD:    cmp_ld = ev_prd;
            LD_BOTH:   cmp_ld = fine_en ? sel_ev : (ev_zero | ev_prd);
            LD_FREEZE: cmp_ld = fine_en ? sel_ev : 1'b0;
            default:   cmp_ld = 1'b0;
        endcase
    end

    // fine compare load: load-select only matters in duty control
    assign fine_ld = cfg_q.ctl_phase ? ev_zero : sel_ev;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            period_q   <= '0;
            cmp_sh_q   <= '0;
            cmp_act_q  <= '0;
            fine_sh_q  <= '0;
            fine_act_q <= '0;
            phase_q    <= '0;
            err_q      <= 1'b0;
        end else begin
            if (cmp_ld)   cmp_act_q  <= cmp_sh_q;
            if (fine_ld)  fine_act_q <= fine_sh_q;
            if (bad_mode) err_q      <= 1'b1;
            if (we_cfg)   cfg_q      <= cfg_t'(wr_data[CFG_W-1:0]);
            if (we_prd)   period_q   <= wr_data[CNT_W-1:0];
            if (we_cmp)   cmp_sh_q   <= wr_data[CNT_W-1:0];
            if (we_fine)  fine_sh_q  <= wr_data[FINE_LSB +: FINE_W];
            if (we_phase) phase_q    <= wr_data[FINE_LSB +: FINE_W];
        end
    end

    assign edge_mode = cfg_q.edge_mode;
    assign ctl_phase = cfg_q.ctl_phase;

endmodule

// File: rtl/fe_timebase.sv
module fe_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_act,
    output logic [CNT_W-1:0] cnt,
    output logic             ev_zero,
    output logic             ev_prd,
    output logic             ev_cmp
);

    logic [CNT_W-1:0] cnt_q;

    assign ev_zero = (cnt_q == '0);
    assign ev_prd  = (cnt_q == period);
    assign ev_cmp  = (cnt_q == cmp_act);
    assign cnt     = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      cnt_q <= '0;
        else if (ev_prd) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/fe_wave_fsm.sv
module fe_wave_fsm
    import fine_edge_pkg::*;
#(
    parameter int FINE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_zero,
    input  logic              ev_cmp,
    input  logic [1:0]        edge_mode,
    input  logic              ctl_phase,
    input  logic [FINE_W-1:0] fine_act,
    input  logic [FINE_W-1:0] phase_val,
    output logic              pwm_out,
    output logic [1:0]        edge_tag,
    output logic [FINE_W-1:0] fine_code
);

    localparam int N_EDGE = 2;  // index 0 rising, 1 falling

    wave_e             state_q, state_d;
    logic              rise, fall;
    logic [FINE_W-1:0] src;
    logic [FINE_W-1:0] gated [N_EDGE];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WV_LOW:  if (ev_zero && !ev_cmp) state_d = WV_HIGH;  // RISE
            WV_HIGH: if (ev_cmp)             state_d = WV_LOW;   // FALL
            default: state_d = WV_LOW;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WV_LOW;
        else        state_q <= state_d;
    end

    assign rise = (state_q == WV_LOW)  && (state_d == WV_HIGH);
    assign fall = (state_q == WV_HIGH) && (state_d == WV_LOW);
    assign src  = ctl_phase ? phase_val : fine_act;

    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        assign gated[g] = edge_mode[g] ? src : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            edge_tag  <= '0;
            fine_code <= '0;
        end else begin
            edge_tag  <= {fall, rise};
            fine_code <= rise ? gated[0] : (fall ? gated[1] : '0);
        end
    end

    assign pwm_out = (state_q == WV_HIGH);

endmodule

// File: rtl/fine_edge_pwm.sv
module fine_edge_pwm #(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int FINE_W = 8,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out,
    output logic [FINE_W-1:0] fine_code,
    output logic [1:0]        edge_tag,
    output logic              cfg_err
);

    logic [1:0]        edge_mode_w;
    logic              ctl_phase_w;
    logic [CNT_W-1:0]  period_w, cmp_act_w, cnt_w;
    logic [FINE_W-1:0] fine_act_w, phase_w;
    logic              ev_zero, ev_prd, ev_cmp;

    fe_regs #(
        .DATA_W(DATA_W), .CNT_W(CNT_W), .FINE_W(FINE_W), .ADDR_W(ADDR_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ev_zero(ev_zero), .ev_prd(ev_prd),
        .edge_mode(edge_mode_w), .ctl_phase(ctl_phase_w),
        .period_q(period_w), .cmp_act_q(cmp_act_w),
        .fine_act_q(fine_act_w), .phase_q(phase_w),
        .err_q(cfg_err)
    );

    fe_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk(clk), .rst_n(rst_n),
        .period(period_w), .cmp_act(cmp_act_w),
        .cnt(cnt_w), .ev_zero(ev_zero), .ev_prd(ev_prd), .ev_cmp(ev_cmp)
    );

    fe_wave_fsm #(.FINE_W(FINE_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .ev_zero(ev_zero), .ev_cmp(ev_cmp),
        .edge_mode(edge_mode_w), .ctl_phase(ctl_phase_w),
        .fine_act(fine_act_w), .phase_val(phase_w),
        .pwm_out(pwm_out), .edge_tag(edge_tag), .fine_code(fine_code)
    );

endmodule

// File: rtl/fine_edge_pwm_chk.sv
module fine_edge_pwm_chk #(
    parameter int CNT_W  = 16,
    parameter int FINE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_out,
    input logic [1:0]        edge_tag,
    input logic [FINE_W-1:0] fine_code,
    input logic              cfg_err,
    input logic [1:0]        edge_mode,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  period
);

    assert_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == period) |=> (cnt == '0));

    assert_tag_onehot_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(edge_tag));

    assert_rise_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_out) |-> (edge_tag == 2'b01));

    assert_fall_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_out) |-> (edge_tag == 2'b10));

    assert_quiet_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_tag == 2'b00) |-> (fine_code == '0));

    assert_unsel_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_tag == 2'b01 && !$past(edge_mode[0])) |-> (fine_code == '0));

    assert_unsel_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_tag == 2'b10 && !$past(edge_mode[1])) |-> (fine_code == '0));

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        !rst_n |-> (!pwm_out && edge_tag == 2'b00 && fine_code == '0 && !cfg_err));

endmodule

bind fine_edge_pwm fine_edge_pwm_chk #(.CNT_W(CNT_W), .FINE_W(FINE_W)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .pwm_out(pwm_out), .edge_tag(edge_tag), .fine_code(fine_code),
    .cfg_err(cfg_err), .edge_mode(edge_mode_w),
    .cnt(cnt_w), .period(period_w)
);

// File: tb/fine_edge_pwm_test.sv
`timescale 1ns/1ps
module fine_edge_pwm_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        pwm_out;
    logic [7:0]  fine_code;
    logic [1:0]  edge_tag;
    logic        cfg_err;

    int    checks = 0;
    int    fails  = 0;
    string focus  = "R10";

    always #2 clk = ~clk;  // 250 MHz

    fine_edge_pwm uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .fine_code(fine_code),
        .edge_tag(edge_tag), .cfg_err(cfg_err)
    );

    // reference state
    logic [15:0] m_cnt, m_prd, m_cmp_sh, m_cmp_act;
    logic [7:0]  m_fine_sh, m_fine_act, m_phase, m_code;
    logic [1:0]  m_emode, m_cload, m_tag;
    logic        m_ctl, m_lsel, m_high, m_err;

    task automatic model_reset();
        m_cnt = 0; m_prd = 0; m_cmp_sh = 0; m_cmp_act = 0;
        m_fine_sh = 0; m_fine_act = 0; m_phase = 0; m_code = 0;
        m_emode = 0; m_cload = 0; m_tag = 0;
        m_ctl = 0; m_lsel = 0; m_high = 0; m_err = 0;
    endtask

    function automatic logic coarse_load(input logic z, input logic p);
        logic fen, sel;
        fen = (m_emode != 2'b00);
        sel = m_lsel ? p : z;
        case (m_cload)
            2'b00:   return z;
            2'b01:   return p;
            2'b10:   return fen ? sel : (z | p);
            default: return fen ? sel : 1'b0;
        endcase
    endfunction

    task automatic model_step(input logic we, input logic [2:0] a, input logic [15:0] d);
        logic z, p, c, cl, fl, nh;
        logic [7:0] src;
        z  = (m_cnt == 0);
        p  = (m_cnt == m_prd);
        c  = (m_cnt == m_cmp_act);
        cl = coarse_load(z, p);
        fl = m_ctl ? z : (m_lsel ? p : z);
        nh = m_high ? !c : (z && !c);
        src = m_ctl ? m_phase : m_fine_act;
        if (!m_high && nh)      begin m_tag = 2'b01; m_code = m_emode[0] ? src : 8'h00; end
        else if (m_high && !nh) begin m_tag = 2'b10; m_code = m_emode[1] ? src : 8'h00; end
        else                    begin m_tag = 2'b00; m_code = 8'h00; end
        if (m_emode != 0 && m_cload[1]) m_err = 1'b1;
        m_high = nh;
        m_cnt  = p ? 16'h0 : m_cnt + 16'h1;
        if (cl) m_cmp_act  = m_cmp_sh;
        if (fl) m_fine_act = m_fine_sh;
        if (we) begin
            case (a)
                3'd0: begin m_emode = d[1:0]; m_ctl = d[2]; m_lsel = d[3]; m_cload = d[5:4]; end
                3'd1: m_prd = d;
                3'd2: m_cmp_sh = d;
                3'd3: m_fine_sh = d[15:8];
                3'd4: m_phase = d[15:8];
                default: ;
            endcase
        end
    endtask

    task automatic check(input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", focus, what, act, exp);
        end
    endtask

    task automatic compare_all();
        check("pwm_out", 16'(pwm_out), 16'(m_high));
        check("edge_tag", 16'(edge_tag), 16'(m_tag));
        check("fine_code", 16'(fine_code), 16'(m_code));
        check("cfg_err", 16'(cfg_err), 16'(m_err));
    endtask

    task automatic cyc(input logic we, input logic [2:0] a, input logic [15:0] d);
        wr_en = we; wr_addr = a; wr_data = d;
        @(posedge clk);
        model_step(we, a, d);
        @(negedge clk);
        wr_en = 1'b0;
        compare_all();
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        cyc(1'b1, a, d);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b0, 3'd0, 16'h0);
    endtask

    task automatic do_reset();
        focus = "R10";
        @(negedge clk);
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        compare_all();
        rst_n = 1'b1;
    endtask

    task automatic random_run(input int n, input logic allow_bad);
        for (int i = 0; i < n; i++) begin
            if ($urandom_range(0, 4) == 0) begin
                logic [2:0]  a;
                logic [15:0] d;
                a = 3'($urandom_range(0, 6));
                d = 16'($urandom);
                case (a)
                    3'd0: d = allow_bad ? 16'(d[5:0]) : 16'(d[4:0]);
                    3'd1: d = 16'($urandom_range(0, 10));
                    3'd2: d = 16'($urandom_range(0, 12));
                    3'd3: if ($urandom_range(0, 3) != 0) d[7:0] = 8'h00;
                    default: ;
                endcase
                wr(a, d);
            end else begin
                idle(1);
            end
        end
    endtask

    initial begin
        #(200000 * 4);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0A11));
        do_reset();                         // R10
        focus = "R11";
        wr(3'd1, 16'd9); wr(3'd2, 16'd4); wr(3'd6, 16'hFFFF); idle(25);
        focus = "R1";
        idle(20);
        focus = "R2";
        wr(3'd0, 16'h0010); wr(3'd2, 16'd7); idle(25);
        wr(3'd0, 16'h0020); wr(3'd2, 16'd2); idle(25);
        wr(3'd0, 16'h0030); wr(3'd2, 16'd6); idle(25);
        focus = "R4";
        wr(3'd0, 16'h0001); wr(3'd2, 16'd5); wr(3'd3, 16'h5A00); idle(25);
        wr(3'd0, 16'h0002); idle(25);
        focus = "R3";
        wr(3'd0, 16'h0003); idle(25);
        focus = "R6";
        wr(3'd0, 16'h000B); wr(3'd3, 16'hC300); idle(25);
        focus = "R5";
        wr(3'd4, 16'h7700); wr(3'd0, 16'h0007); idle(25);
        wr(3'd4, 16'h1100); idle(15);
        focus = "R7";
        wr(3'd0, 16'h000F); wr(3'd3, 16'h2200); idle(12);
        wr(3'd0, 16'h000B); idle(25);
        focus = "R8";
        wr(3'd3, 16'h33FF); idle(25);
        wr(3'd0, 16'h0007); wr(3'd4, 16'h44AB); idle(20);
        focus = "R9";
        wr(3'd0, 16'h0031); wr(3'd2, 16'd3); idle(25);
        wr(3'd0, 16'h0029); wr(3'd2, 16'd8); idle(25);
        do_reset();
        focus = "R1";
        random_run(2000, 1'b0);
        do_reset();
        focus = "R9";
        random_run(2000, 1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule